// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is the queue a processor core places between the point where stores retire and its private data cache. Retired stores are accepted at once and do not wait for the cache line to be owned. The queue then empties itself in the background. For each entry, oldest first, it asks the coherence layer for ownership of the entry's line. When the grant arrives, it writes the entry into the cache. Only the issuing core can see the queued values. Loads search the queue first and read the cache only when no queued store covers their address.

A full fence and a locked read-modify-write share the same mechanism. While either request is raised, new loads and new stores are held off. The request is acknowledged only once every queued store has reached the cache.

Draining is run by a two-state machine. In `DR_IDLE` no ownership request is raised. The transition *start* moves it to `DR_WAIT_GRANT` on the clock edge after the queue is seen non-empty. In `DR_WAIT_GRANT` the head entry's line is requested. The transition *retire* takes place on a grant: it commits and frees the head. After *retire* the machine stays in `DR_WAIT_GRANT` if entries remain. The transition *settle* returns it to `DR_IDLE` when the entry leaving was the last one and no store enters in that cycle. Without a grant the machine stays where it is.

Top module: `store_forward_queue`

## Requirements
- R1: When no fence or lock request is raised and fewer than 16 entries are held, `st_ready` is high whatever the ownership state, and a store with `st_valid` high is taken in that cycle.
- R2: Stores reach the cache on `c_wr_en` / `c_wr_addr` / `c_wr_data` strictly in the order they were accepted.
- R3: In `DR_WAIT_GRANT`, `rfo_req` is high and `rfo_line` equals the head entry's address bits [AW-1:6]. A cycle with `rfo_req` and `rfo_grant` both high writes the head to the cache and frees it in that cycle. `rfo_grant` has no effect while `rfo_req` is low. `rfo_req` first rises on the cycle after the queue turns non-empty.
- R4: A load whose full address equals a queued entry's address returns that entry's data with `ld_hit` high and `c_rd_en` low.
- R5: When several queued entries match a load exactly, the data comes from the most recently accepted of them.
- R6: A load with no queued entry in its word (address bits [AW-1:2]) reads the cache (`c_rd_en` high, data from `c_rd_data`), even while older stores to other addresses are still waiting.
- R7: If a queued entry lies in the load's word but its full address differs, `ld_ready` is low until that entry drains. This holds even when another entry matches exactly.
- R8: With 16 entries held, `st_ready` is low unless the head retires in that cycle, in which case a new store is accepted in the same cycle. The occupancy never exceeds 16.
- R9: While `fence_req` is high, `ld_ready` and `st_ready` are low, and `fence_ack` is high exactly when the queue is empty.
- R10: `lock_req` behaves like `fence_req`, with its own acknowledgement `lock_ack`.
- R11: A store accepted in the same cycle as a load counts as younger and is not forwarded to it. An entry that retires in the same cycle as a load is still forwarded.
- R12: After reset the queue is empty, `rfo_req` and `c_wr_en` are low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Retired store present |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data word |
| st_ready | output | 1 | Store accepted this cycle when valid |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | AW | Load byte address |
| ld_ready | output | 1 | Load may complete this cycle |
| ld_data | output | DW | Load result, forwarded or from cache |
| ld_hit | output | 1 | Completing load was served from the queue |
| fence_req | input | 1 | Full fence pending |
| fence_ack | output | 1 | Fence may complete, queue empty |
| lock_req | input | 1 | Locked read-modify-write pending |
| lock_ack | output | 1 | Locked operation may proceed, queue empty |
| rfo_req | output | 1 | Ownership request for the head line |
| rfo_line | output | AW-6 | Line address of the head entry |
| rfo_grant | input | 1 | Line held in modified state |
| c_rd_en | output | 1 | Cache read for a completing load |
| c_rd_addr | output | AW | Cache read address |
| c_rd_data | input | DW | Cache read data, same cycle |
| c_wr_en | output | 1 | Commit of the head entry |
| c_wr_addr | output | AW | Commit address |
| c_wr_data | output | DW | Commit data |

## Verification
Three activities can coincide in one cycle. The first pair is a commit of the head and the acceptance of a new store, which matters most when all 16 slots are held. The second pair is a commit and a load that forwards from the very entry that is leaving. The bench provokes the first by filling the queue with grants withheld and then granting in the same cycle as a further store. It provokes the second by loading a queued address on every cycle of a granted drain, and it adds a same-cycle store and load to one address. A behavioural reference model of the queue and the memory image predicts `st_ready`, the commit stream, the occupancy and the load value for every one of these cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Drain controller states
    typedef enum logic [0:0] {
        DR_IDLE       = 1'b0,
        DR_WAIT_GRANT = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] ord_addr [DEPTH],
    output logic [DW-1:0] ord_data [DEPTH],
    output logic [DEPTH-1:0] ord_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [PW-1:0] head_q, tail_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail_q] <= push_addr;
            slot_data[tail_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push) tail_q <= wrap_inc(tail_q);
            if (pop)  head_q <= wrap_inc(head_q);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign full      = (int'(count) == DEPTH);
    assign empty     = (count == '0);
    assign head_addr = slot_addr[head_q];
    assign head_data = slot_data[head_q];

    // Entries re-indexed by age: index 0 is the oldest
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = int'(head_q) + i;
            if (s >= DEPTH) s = s - DEPTH;
            ord_addr[i]  = slot_addr[PW'(s)];
            ord_data[i]  = slot_data[PW'(s)];
            ord_valid[i] = (CW'(i) < count);
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    a_r8_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
endmodule

// File: rtl/sb_search.sv
module sb_search #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int WOFF  = 2
) (
    input  logic [AW-1:0]    ld_addr,
    input  logic [AW-1:0]    ord_addr [DEPTH],
    input  logic [DW-1:0]    ord_data [DEPTH],
    input  logic [DEPTH-1:0] ord_valid,
    output logic             hit,
    output logic [DW-1:0]    hit_data,
    output logic             partial
);
    timeunit 1ns;
    timeprecision 1ps;

    // Scan from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        partial  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ord_valid[i] && ord_addr[i][AW-1:WOFF] == ld_addr[AW-1:WOFF]) begin
                if (ord_addr[i] == ld_addr) begin
                    hit      = 1'b1;
                    hit_data = ord_data[i];
                end else begin
                    partial  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sb_drain_fsm.sv
module sb_drain_fsm
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic last,
    input  logic push,
    input  logic rfo_grant,
    output logic rfo_req,
    output logic pop
);
    timeunit 1ns;
    timeprecision 1ps;

    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: begin
                if (pending) state_d = DR_WAIT_GRANT;          // start
            end
            DR_WAIT_GRANT: begin
                if (rfo_grant && last && !push) state_d = DR_IDLE; // settle
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        rfo_req = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            DR_IDLE: ;
            DR_WAIT_GRANT: begin
                rfo_req = 1'b1;
                pop     = rfo_grant;                           // retire
            end
            default: ;
        endcase
    end

    a_r3_wait_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DR_WAIT_GRANT) |-> pending);
endmodule

// File: rtl/store_forward_queue.sv
module store_forward_queue #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int WORD_BYTES = 4,
    parameter int LINE_BYTES = 64,
    localparam int WOFF      = $clog2(WORD_BYTES),
    localparam int LOFF      = $clog2(LINE_BYTES),
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    output logic            st_ready,
    input  logic            ld_valid,
    input  logic [AW-1:0]   ld_addr,
    output logic            ld_ready,
    output logic [DW-1:0]   ld_data,
    output logic            ld_hit,
    input  logic            fence_req,
    output logic            fence_ack,
    input  logic            lock_req,
    output logic            lock_ack,
    output logic            rfo_req,
    output logic [AW-LOFF-1:0] rfo_line,
    input  logic            rfo_grant,
    output logic            c_rd_en,
    output logic [AW-1:0]   c_rd_addr,
    input  logic [DW-1:0]   c_rd_data,
    output logic            c_wr_en,
    output logic [AW-1:0]   c_wr_addr,
    output logic [DW-1:0]   c_wr_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic            push, pop, full, empty;
    logic [CW-1:0]   count;
    logic [AW-1:0]   head_addr;
    logic [DW-1:0]   head_data;
    logic [AW-1:0]   ord_addr [DEPTH];
    logic [DW-1:0]   ord_data [DEPTH];
    logic [DEPTH-1:0] ord_valid;
    logic            hit, partial, sync_busy;
    logic [DW-1:0]   hit_data;

    assign sync_busy = fence_req | lock_req;
    assign st_ready  = !sync_busy && (!full || pop);
    assign push      = st_valid && st_ready;

    sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk, .rst_n, .push,
        .push_addr(st_addr), .push_data(st_data),
        .pop, .head_addr, .head_data, .count, .full, .empty,
        .ord_addr, .ord_data, .ord_valid
    );

    sb_search #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WOFF(WOFF)) u_search (
        .ld_addr, .ord_addr, .ord_data, .ord_valid,
        .hit, .hit_data, .partial
    );

    sb_drain_fsm u_drain (
        .clk, .rst_n,
        .pending(!empty),
        .last(count == CW'(1)),
        .push, .rfo_grant, .rfo_req, .pop
    );

    assign ld_ready  = !sync_busy && !partial;
    assign ld_data   = hit ? hit_data : c_rd_data;
    assign ld_hit    = ld_valid && ld_ready && hit;
    assign c_rd_en   = ld_valid && ld_ready && !hit;
    assign c_rd_addr = ld_addr;

    assign rfo_line  = head_addr[AW-1:LOFF];
    assign c_wr_en   = pop;
    assign c_wr_addr = head_addr;
    assign c_wr_data = head_data;

    assign fence_ack = fence_req && empty;
    assign lock_ack  = lock_req && empty;

    a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rfo_req && !rfo_grant) |=> (rfo_line == $past(rfo_line)));
    a_r3_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_en && !push) |=> (count == $past(count) - CW'(1)));
    a_r9_sync_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_busy && !empty) |=> !$rose(count != '0) && (count <= $past(count)));
endmodule

// File: tb/tb_store_forward_queue.sv
module tb_store_forward_queue;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, ld_valid = 0, fence_req = 0, lock_req = 0, rfo_grant = 0;
    logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
    logic        st_ready, ld_ready, ld_hit, fence_ack, lock_ack, rfo_req;
    logic        c_rd_en, c_wr_en;
    logic [31:0] ld_data, c_rd_addr, c_wr_addr, c_wr_data, c_rd_data;
    logic [25:0] rfo_line;

    logic [31:0] cmem [256];
    logic [31:0] refmem [256];
    logic [31:0] qa [$];
    logic [31:0] qd [$];
    bit          mreq;
    bit          done;
    bit          last_ack;
    int          n_chk, n_bad;

    always #2 clk = ~clk;

    store_forward_queue dut (
        .clk, .rst_n, .st_valid, .st_addr, .st_data, .st_ready,
        .ld_valid, .ld_addr, .ld_ready, .ld_data, .ld_hit,
        .fence_req, .fence_ack, .lock_req, .lock_ack,
        .rfo_req, .rfo_line, .rfo_grant,
        .c_rd_en, .c_rd_addr, .c_rd_data, .c_wr_en, .c_wr_addr, .c_wr_data
    );

    assign c_rd_data = cmem[c_rd_addr[9:2]];

    always @(posedge clk) if (c_wr_en) cmem[c_wr_addr[9:2]] <= c_wr_data;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare against the model, advance the model
    task automatic cyc(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                       input logic lv, input logic [31:0] la,
                       input logic fr, input logic lr, input logic g);
        int  n;
        bit  busy, pop_e, part, hit, e_st, e_ld;
        logic [31:0] hd;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd;
        ld_valid = lv; ld_addr = la;
        fence_req = fr; lock_req = lr; rfo_grant = g;
        #1;
        n     = qa.size();
        busy  = fr || lr;
        pop_e = mreq && g;
        part  = 0; hit = 0; hd = '0;
        for (int i = 0; i < n; i++) begin
            if (qa[i][31:2] == la[31:2]) begin
                if (qa[i] == la) begin hit = 1; hd = qd[i]; end
                else part = 1;
            end
        end
        e_st = !busy && (n < DEPTH || pop_e);
        e_ld = !busy && !part;
        chk("R1 R8 R9 st_ready", {31'd0, st_ready}, {31'd0, e_st});
        chk("R7 R9 ld_ready", {31'd0, ld_ready}, {31'd0, e_ld});
        chk("R4 ld_hit", {31'd0, ld_hit}, {31'd0, lv && e_ld && hit});
        chk("R4 R6 c_rd_en", {31'd0, c_rd_en}, {31'd0, lv && e_ld && !hit});
        if (lv && e_ld)
            chk("R4 R5 R6 R11 ld_data", ld_data, hit ? hd : refmem[la[9:2]]);
        chk("R3 rfo_req", {31'd0, rfo_req}, {31'd0, mreq});
        if (mreq) chk("R3 rfo_line", {6'd0, rfo_line}, {6'd0, qa[0][31:6]});
        chk("R3 c_wr_en", {31'd0, c_wr_en}, {31'd0, pop_e});
        if (pop_e) begin
            chk("R2 c_wr_addr", c_wr_addr, qa[0]);
            chk("R2 c_wr_data", c_wr_data, qd[0]);
        end
        chk("R9 fence_ack", {31'd0, fence_ack}, {31'd0, fr && n == 0});
        chk("R10 lock_ack", {31'd0, lock_ack}, {31'd0, lr && n == 0});
        last_ack = (fr || lr) && n == 0;
        if (pop_e) begin
            refmem[qa[0][9:2]] = qd[0];
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        if (sv && e_st) begin
            qa.push_back(sa);
            qd.push_back(sd);
        end
        if (!mreq) mreq = (n > 0);
        else if (pop_e) mreq = (qa.size() > 0);
    endtask

    task automatic drain_all(input logic [31:0] la);
        for (int k = 0; k < 60; k++) cyc(0, 0, 0, 1, la, 0, 0, 1);
    endtask

    task automatic sync_seq(input bit use_lock);
        for (int k = 0; k < 3; k++) cyc(1, 32'h0C0 + 32'(k * 4), 32'h5000 + 32'(k), 0, 0, 0, 0, 0);
        last_ack = 0;
        for (int k = 0; k < 6; k++)
            cyc(1, 32'h0D0, 32'h6000, 1, 32'h0C0, !use_lock, use_lock, 0);
        for (int k = 0; k < 40 && !last_ack; k++)
            cyc(1, 32'h0D0, 32'h6000, 1, 32'h0C0, !use_lock, use_lock, 1);
        chk(use_lock ? "R10 lock acknowledged" : "R9 fence acknowledged",
            {31'd0, last_ack}, 32'd1);
        cyc(0, 0, 0, 1, 32'h0C0, 0, 0, 0);
    endtask

    initial begin
        int sync;
        for (int i = 0; i < 256; i++) begin
            cmem[i]   = 32'h1111_0000 + 32'(i);
            refmem[i] = 32'h1111_0000 + 32'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R12 st_ready after reset", {31'd0, st_ready}, 32'd1);
        chk("R12 rfo_req after reset", {31'd0, rfo_req}, 32'd0);
        chk("R12 c_wr_en after reset", {31'd0, c_wr_en}, 32'd0);
        // Fill all 16 slots with grants withheld; two duplicates at 0x10
        for (int i = 0; i < 14; i++) cyc(1, 32'(i * 4), 32'hA000 + 32'(i), 0, 0, 0, 0, 0);
        cyc(1, 32'h10, 32'hB001, 0, 0, 0, 0, 0);
        cyc(1, 32'h10, 32'hB002, 0, 0, 0, 0, 0);
        // R8 full blocks, R5 youngest forward
        cyc(1, 32'h40, 32'hC000, 1, 32'h10, 0, 0, 0);
        chk("R8 full refuses store", {31'd0, st_ready}, 32'd0);
        chk("R5 youngest duplicate", ld_data, 32'hB002);
        // R6 bypass to cache while stores pending
        cyc(0, 0, 0, 1, 32'h200, 0, 0, 0);
        chk("R6 miss reads cache", ld_data, 32'h1111_0080);
        // R7 partial overlap stalls
        cyc(0, 0, 0, 1, 32'h11, 0, 0, 0);
        chk("R7 partial stall", {31'd0, ld_ready}, 32'd0);
        // R8 full with drain in same cycle accepts
        cyc(1, 32'h44, 32'hC001, 0, 0, 0, 0, 1);
        chk("R8 accept while draining", {31'd0, st_ready}, 32'd1);
        // R2 R11 drain in order while loading a queued address
        for (int k = 0; k < 40; k++) cyc(0, 0, 0, 1, 32'h10, 0, 0, k[0]);
        drain_all(32'h10);
        // R11 same-cycle store and load: load sees the cache
        cyc(1, 32'h80, 32'hD00D, 1, 32'h80, 0, 0, 0);
        chk("R11 same-cycle store not forwarded", ld_data, 32'h1111_0020);
        drain_all(32'h80);
        sync_seq(0);
        drain_all(0);
        sync_seq(1);
        drain_all(0);
        // Random traffic
        sync = 0;
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] sa, la;
            bit fr, lr;
            sa = 32'(($urandom % 24) * 4) + (($urandom % 12 == 0) ? 32'd1 : 32'd0);
            la = 32'(($urandom % 24) * 4) + (($urandom % 12 == 0) ? 32'd1 : 32'd0);
            if (sync != 0 && last_ack) sync = 0;
            else if (sync == 0 && $urandom % 50 == 0) sync = 1 + int'($urandom % 2);
            fr = (sync == 1);
            lr = (sync == 2);
            cyc($urandom % 2 == 0, sa, $urandom, $urandom % 2 == 0, la, fr, lr,
                $urandom % 3 == 0);
        end
        drain_all(0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule